// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer seen by software as three 32-bit registers. An external tick enable, typically a 256 Hz strobe from a prescaler outside the block, drives a 12-bit down-counter. Software must restart the counter before it passes zero. The restart is a keyed command, and the block accepts it only once the count has fallen into a window. The window is bounded by a programmable delta value.

A restart that comes too early is recorded as a fault. So is a counter underflow. The mode register sets how faults are reported: an interrupt level, a one-cycle reset request with an optional processor-only qualifier, or both. The mode register also holds the reload value, the window delta, a disable bit and two halt bits. The mode register locks after its first write. Until it is written it reads a fixed power-on value, and that value lets the watchdog run at full length with restarts always legal.

Address map (`bus_addr_i`): 0 is the restart control register, 1 is the mode register and 2 is the status register. A read returns data on `bus_rdata_o` one cycle after the read strobe. In every other cycle the read data is zero.

Top module: `wwdt_top`

## Requirements
- R1: The 12-bit counter decrements by one on each accepted tick. Its power-on count is 0xFFF.
- R2: Only the first mode write after reset is accepted. That write also loads the counter with the new reload field. Every later mode write leaves the mode register and the counter unchanged.
- R3: The mode register reads 0x3FFF2FFF after reset. Its layout is: bits 11:0 reload, bit 12 interrupt enable, bit 13 reset enable, bit 14 processor-only reset, bit 15 disable, bits 27:16 window delta, bit 28 debug halt, bit 29 idle halt. Reads of the control register return 0.
- R4: A restart is a control write with 0xA5 in bits 31:24 and bit 0 set. When the count is at or below the delta, a restart reloads the counter and raises no fault.
- R5: A restart that arrives while the count is above the delta leaves the counter unchanged and sets status bit 1.
- R6: A control write whose key byte is not 0xA5, or whose bit 0 is clear, has no effect.
- R7: A tick at count 0 sets status bit 0 and reloads the counter. If a legal restart or an accepted mode write falls in the same cycle, the restart or the write wins and no underflow is recorded.
- R8: While the disable bit is set, the counter holds, restarts are ignored and no fault is raised.
- R9: Ticks are ignored while `core_idle_i` is high with idle halt set. Ticks are also ignored while `dbg_halt_i` is high with debug halt set.
- R10: Status bit 0 records underflow and bit 1 records early restart. A status read clears both bits. A fault in the same cycle as the read is kept.
- R11: `irq_o` is high whenever the interrupt enable bit is set and any status bit is set.
- R12: `rst_req_o` pulses high for one cycle, the cycle after a fault, when reset enable is set. `cpu_rst_only_o` pulses with it when the processor-only bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaled count enable |
| core_idle_i | input | 1 | Core is idle |
| dbg_halt_i | input | 1 | Debugger halt |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Fault interrupt level |
| rst_req_o | output | 1 | Reset request pulse |
| cpu_rst_only_o | output | 1 | Restrict reset to the processor |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a status read clearing the flags while a new fault sets one. The second pair is a restart or mode write landing on the tick that would underflow the counter. The bench provokes both in directed sequences and with several thousand cycles of mixed reads, restarts and ticks at small reload values. In those cycles overlaps happen often. It judges every cycle against a behavioural model that follows the stated priorities: the new fault survives the clear, and the reload wins over the underflow.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
   localparam int          BUS_W     = 32;
   localparam int          DELTA_LSB = 16;
   localparam logic [7:0]  CMD_KEY   = 8'hA5;
   localparam logic [31:0] MODE_RST  = 32'h3FFF_2FFF;

   localparam int BIT_IRQEN   = 12;
   localparam int BIT_RSTEN   = 13;
   localparam int BIT_CPUONLY = 14;
   localparam int BIT_OFF     = 15;
   localparam int BIT_DBGH    = 28;
   localparam int BIT_IDLEH   = 29;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_MODE = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } wwdt_sel_e;

   typedef struct packed {
      logic idle_halt;
      logic dbg_halt;
      logic off;
      logic cpu_only;
      logic rst_en;
      logic irq_en;
   } wwdt_ctl_t;

   function automatic wwdt_ctl_t decode_ctl(input logic [BUS_W-1:0] m);
      wwdt_ctl_t c;
      c.idle_halt = m[BIT_IDLEH];
      c.dbg_halt  = m[BIT_DBGH];
      c.off       = m[BIT_OFF];
      c.cpu_only  = m[BIT_CPUONLY];
      c.rst_en    = m[BIT_RSTEN];
      c.irq_en    = m[BIT_IRQEN];
      return c;
   endfunction
endpackage

// File: rtl/wwdt_modereg.sv
module wwdt_modereg
   import wwdt_pkg::*;
#(
   parameter logic [BUS_W-1:0] RST_VAL = MODE_RST
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [BUS_W-1:0] wdata_i,
   output logic [BUS_W-1:0] mode_o,
   output logic             accept_o
);
   logic             locked_q;
   logic [BUS_W-1:0] mode_q;

   assign accept_o = wr_i && !locked_q;
   assign mode_o   = mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= RST_VAL;
         locked_q <= 1'b0;
      end else if (accept_o) begin
         mode_q   <= wdata_i;
         locked_q <= 1'b1;
      end
   end

   // R2
   mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> $stable(mode_q));
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic [CNT_W-1:0] delta_i,
   input  logic             restart_req_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             early_o,
   output logic             uf_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             above_win, restart_ok;

   always_comb begin
      above_win  = cnt_q > delta_i;
      early_o    = restart_req_i && above_win;
      restart_ok = restart_req_i && !above_win;
      uf_o       = step_i && (cnt_q == '0) && !restart_ok && !load_i;
      if (load_i)               cnt_d = load_val_i;
      else if (restart_ok)      cnt_d = reload_i;
      else if (step_i) begin
         if (cnt_q == '0)       cnt_d = reload_i;
         else                   cnt_d = cnt_q - 1'b1;
      end else                  cnt_d = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= CNT_MAX;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   // R1
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !restart_req_i && cnt_q != '0)
      |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
   // R7
   uf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf_o |=> cnt_q == $past(reload_i));
   // R4
   restart_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_req_i && !early_o && !load_i) |=> cnt_q == $past(reload_i));
   // R5
   early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (early_o && !step_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wwdt_fault.sv
module wwdt_fault #(
   parameter int RST_STRETCH = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       uf_i,
   input  logic       early_i,
   input  logic       clr_i,
   input  logic       irq_en_i,
   input  logic       rst_en_i,
   input  logic       cpu_only_i,
   output logic [1:0] status_o,
   output logic       irq_o,
   output logic       rst_req_o,
   output logic       cpu_only_o
);
   logic [1:0] status_q;
   logic       fault;

   assign fault = uf_i || early_i;

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (clr_i ? 2'b00 : status_q) | {early_i, uf_i};
   end

   assign status_o = status_q;
   assign irq_o    = irq_en_i && (status_q != 2'b00);

   generate
      if (RST_STRETCH == 1) begin : g_pulse
         logic rst_q, cpu_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rst_q <= 1'b0;
               cpu_q <= 1'b0;
            end else begin
               rst_q <= fault && rst_en_i;
               cpu_q <= fault && rst_en_i && cpu_only_i;
            end
         end
         assign rst_req_o  = rst_q;
         assign cpu_only_o = cpu_q;

         // R12
         rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_req_o |-> $past(rst_en_i) && $past(uf_i || early_i));
      end else begin : g_stretch
         localparam int SW = $clog2(RST_STRETCH + 1);
         localparam logic [SW-1:0] LEN = SW'(RST_STRETCH);
         logic [SW-1:0] left_q;
         logic          cpu_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               left_q <= '0;
               cpu_q  <= 1'b0;
            end else if (fault && rst_en_i) begin
               left_q <= LEN;
               cpu_q  <= cpu_only_i;
            end else if (left_q != '0) begin
               left_q <= left_q - 1'b1;
            end
         end
         assign rst_req_o  = left_q != '0;
         assign cpu_only_o = rst_req_o && cpu_q;
      end
   endgenerate

   // R10
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !fault) |=> status_q == 2'b00);
   // R12
   cpu_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_only_o |-> rst_req_o);
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
   import wwdt_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int RST_STRETCH = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_i,
   input  logic        core_idle_i,
   input  logic        dbg_halt_i,
   input  logic        bus_wr_i,
   input  logic        bus_rd_i,
   input  logic [1:0]  bus_addr_i,
   input  logic [31:0] bus_wdata_i,
   output logic [31:0] bus_rdata_o,
   output logic        irq_o,
   output logic        rst_req_o,
   output logic        cpu_rst_only_o
);
   localparam int KEY_LSB = BUS_W - 8;

   initial begin
      cnt_w_range_chk: assert (CNT_W >= 2 && CNT_W <= 12);
      stretch_range_chk: assert (RST_STRETCH >= 1 && RST_STRETCH <= 255);
   end

   wwdt_sel_e        sel;
   logic [BUS_W-1:0] mode;
   wwdt_ctl_t        ctl;
   logic             mode_ld, halted, step, cmd_ok, restart_req;
   logic [CNT_W-1:0] cnt, reload, delta;
   logic             early, uf;
   logic [1:0]       status;
   logic [BUS_W-1:0] rdata_q;

   assign sel = wwdt_sel_e'(bus_addr_i);

   wwdt_modereg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (bus_wr_i && sel == SEL_MODE),
      .wdata_i  (bus_wdata_i),
      .mode_o   (mode),
      .accept_o (mode_ld)
   );

   always_comb begin
      ctl         = decode_ctl(mode);
      reload      = mode[CNT_W-1:0];
      delta       = mode[DELTA_LSB +: CNT_W];
      halted      = (core_idle_i && ctl.idle_halt) || (dbg_halt_i && ctl.dbg_halt);
      step        = tick_i && !halted && !ctl.off;
      cmd_ok      = bus_wr_i && sel == SEL_CTRL
                    && bus_wdata_i[BUS_W-1:KEY_LSB] == CMD_KEY && bus_wdata_i[0];
      restart_req = cmd_ok && !ctl.off;
   end

   wwdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk           (clk),
      .rst_n         (rst_n),
      .step_i        (step),
      .load_i        (mode_ld),
      .load_val_i    (bus_wdata_i[CNT_W-1:0]),
      .reload_i      (reload),
      .delta_i       (delta),
      .restart_req_i (restart_req),
      .cnt_o         (cnt),
      .early_o       (early),
      .uf_o          (uf)
   );

   wwdt_fault #(.RST_STRETCH(RST_STRETCH)) u_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .uf_i       (uf),
      .early_i    (early),
      .clr_i      (bus_rd_i && sel == SEL_STAT),
      .irq_en_i   (ctl.irq_en),
      .rst_en_i   (ctl.rst_en),
      .cpu_only_i (ctl.cpu_only),
      .status_o   (status),
      .irq_o      (irq_o),
      .rst_req_o  (rst_req_o),
      .cpu_only_o (cpu_rst_only_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rdata_q <= '0;
      else if (bus_rd_i) begin
         case (sel)
            SEL_MODE: rdata_q <= mode;
            SEL_STAT: rdata_q <= {{(BUS_W-2){1'b0}}, status};
            default:  rdata_q <= '0;
         endcase
      end else rdata_q <= '0;
   end

   assign bus_rdata_o = rdata_q;

   // R8
   off_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.off && !mode_ld) |=> $stable(cnt));
   // R8
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.off |-> !(uf || early));
   // R9
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !mode_ld && !restart_req) |=> $stable(cnt));
endmodule

// File: tb/wwdt_top_tb.sv
module wwdt_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] RSTV = 32'h3FFF_2FFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 0, core_idle_i = 0, dbg_halt_i = 0;
   logic        bus_wr_i = 0, bus_rd_i = 0;
   logic [1:0]  bus_addr_i = 0;
   logic [31:0] bus_wdata_i = 0;
   logic [31:0] bus_rdata_o;
   logic        irq_o, rst_req_o, cpu_rst_only_o;

   int checks = 0, failures = 0, cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wwdt_top u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .core_idle_i(core_idle_i),
      .dbg_halt_i(dbg_halt_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
      .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
      .irq_o(irq_o), .rst_req_o(rst_req_o), .cpu_rst_only_o(cpu_rst_only_o)
   );

   // behavioural reference model
   logic [31:0] m_mode, m_rdata;
   bit          m_lock, m_rst, m_cpu;
   int          m_cnt;
   bit [1:0]    m_stat;
   int          rl, dl;
   bit          m_off, m_step, m_cmd, m_mwr, m_early, m_rs, m_uf;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = RSTV; m_lock = 0; m_cnt = 4095; m_stat = 0;
         m_rdata = 0; m_rst = 0; m_cpu = 0;
      end else begin
         rl = int'(m_mode[11:0]);
         dl = int'(m_mode[27:16]);
         m_off  = m_mode[15];
         m_step = tick_i && !m_off && !(core_idle_i && m_mode[29]) && !(dbg_halt_i && m_mode[28]);
         m_cmd  = bus_wr_i && bus_addr_i == 0 && bus_wdata_i[31:24] == 8'hA5 && bus_wdata_i[0] && !m_off;
         m_mwr  = bus_wr_i && bus_addr_i == 1 && !m_lock;
         m_early = m_cmd && m_cnt > dl;
         m_rs    = m_cmd && m_cnt <= dl;
         m_uf    = m_step && m_cnt == 0 && !m_rs && !m_mwr;
         if (bus_rd_i) m_rdata = (bus_addr_i == 1) ? m_mode : (bus_addr_i == 2) ? {30'd0, m_stat} : 0;
         else m_rdata = 0;
         if (bus_rd_i && bus_addr_i == 2) m_stat = 0;
         m_stat = m_stat | {m_early, m_uf};
         m_rst = (m_early || m_uf) && m_mode[13];
         m_cpu = m_rst && m_mode[14];
         if (m_mwr) m_cnt = int'(bus_wdata_i[11:0]);
         else if (m_rs) m_cnt = rl;
         else if (m_step) m_cnt = (m_cnt == 0) ? rl : m_cnt - 1;
         if (m_mwr) begin m_mode = bus_wdata_i; m_lock = 1; end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(irq_o == (m_mode[12] && m_stat != 0), "R11 irq", 32'(irq_o), 32'(m_mode[12] && m_stat != 0));
         chk(rst_req_o == m_rst, "R12 rst_req", 32'(rst_req_o), 32'(m_rst));
         chk(cpu_rst_only_o == m_cpu, "R12 cpu_only", 32'(cpu_rst_only_o), 32'(m_cpu));
         chk(bus_rdata_o == m_rdata, "R10 rdata", bus_rdata_o, m_rdata);
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; tick_i = 0; core_idle_i = 0; dbg_halt_i = 0; bus_wr_i = 0; bus_rd_i = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_wr_i = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd_i = 1; bus_addr_i = a;
      @(negedge clk);
      bus_rd_i = 0;
      d = bus_rdata_o;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_i = 1;
      end
      @(negedge clk);
      tick_i = 0;
   endtask

   logic [31:0] v;

   initial begin
      // phase A: reset state, lock, window
      do_reset();
      chk(irq_o == 0 && rst_req_o == 0, "R12 reset outputs", 32'({irq_o, rst_req_o}), 0);
      rd(1, v); chk(v == RSTV, "R3 mode reset value", v, RSTV);
      rd(2, v); chk(v == 0, "R10 status at reset", v, 0);
      rd(0, v); chk(v == 0, "R3 control reads zero", v, 0);
      wr(1, 32'h0008_3014);                       // reload 20, delta 8, irq+rst enable
      rd(1, v); chk(v == 32'h0008_3014, "R2 first mode write", v, 32'h0008_3014);
      wr(1, 32'h1234_5678);
      rd(1, v); chk(v == 32'h0008_3014, "R2 second write ignored", v, 32'h0008_3014);
      wr(0, 32'hA500_0001);                       // count 20 > 8: early
      chk(rst_req_o == 1 && irq_o == 1, "R12 R11 after early", 32'({rst_req_o, irq_o}), 3);
      rd(2, v); chk(v == 2, "R5 early flag", v, 2);
      rd(2, v); chk(v == 0, "R10 cleared by read", v, 0);
      wr(0, 32'h5A00_0001);
      wr(0, 32'hA500_0000);
      rd(2, v); chk(v == 0, "R6 bad key or bit ignored", v, 0);
      ticks(12);                                  // 20 -> 8
      wr(0, 32'hA500_0001);
      rd(2, v); chk(v == 0, "R4 restart inside window", v, 0);
      ticks(21);                                  // 20 -> 0 -> underflow
      rd(2, v); chk(v == 1, "R7 underflow flag", v, 1);

      // phase B: exact count, halts, processor-only reset
      do_reset();
      wr(1, 32'h3005_6005);                       // reload 5, delta 5, halts, rst + cpu-only
      ticks(5);
      rd(2, v); chk(v == 0, "R1 five ticks no underflow", v, 0);
      ticks(1);
      chk(rst_req_o == 1 && cpu_rst_only_o == 1, "R12 cpu-only pulse", 32'({rst_req_o, cpu_rst_only_o}), 3);
      rd(2, v); chk(v == 1, "R1 R7 sixth tick underflows", v, 1);
      @(negedge clk); core_idle_i = 1;
      ticks(20);
      @(negedge clk); core_idle_i = 0; dbg_halt_i = 1;
      ticks(20);
      @(negedge clk); dbg_halt_i = 0;
      rd(2, v); chk(v == 0, "R9 halts freeze count", v, 0);
      ticks(5);
      rd(2, v); chk(v == 0, "R9 count resumes intact", v, 0);
      // restart on the tick that would underflow: restart wins
      @(negedge clk);
      tick_i = 1; bus_wr_i = 1; bus_addr_i = 0; bus_wdata_i = 32'hA500_0001;
      @(negedge clk); tick_i = 0; bus_wr_i = 0;
      rd(2, v); chk(v == 0, "R7 restart beats underflow", v, 0);
      // read on the underflow tick: new flag survives
      ticks(5);
      @(negedge clk); tick_i = 1; bus_rd_i = 1; bus_addr_i = 2;
      @(negedge clk); tick_i = 0; bus_rd_i = 0;
      chk(bus_rdata_o == 0, "R10 read before event", bus_rdata_o, 0);
      rd(2, v); chk(v == 1, "R10 same-cycle event kept", v, 1);

      // phase C: disabled
      do_reset();
      wr(1, 32'h0000_B003);                       // off, reload 3, delta 0
      ticks(30);
      wr(0, 32'hA500_0001);
      chk(irq_o == 0 && rst_req_o == 0, "R8 no fault outputs", 32'({irq_o, rst_req_o}), 0);
      rd(2, v); chk(v == 0, "R8 disabled no status", v, 0);

      // phase D: mixed traffic judged by the model
      for (int r = 0; r < 4; r++) begin
         do_reset();
         for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            tick_i      = ($urandom_range(0, 3) != 0);
            core_idle_i = ($urandom_range(0, 9) == 0);
            dbg_halt_i  = ($urandom_range(0, 9) == 0);
            bus_rd_i    = ($urandom_range(0, 2) == 0);
            bus_wr_i    = ($urandom_range(0, 5) == 0);
            bus_addr_i  = 2'($urandom_range(0, 3));
            if (bus_addr_i == 1)
               bus_wdata_i = {2'b00, 2'($urandom), 4'd0, 12'($urandom_range(0, 20)),
                              1'b0, 3'($urandom), 12'($urandom_range(0, 31))};
            else
               bus_wdata_i = ($urandom_range(0, 4) == 0) ? 32'($urandom) : 32'hA500_0001;
         end
         @(negedge clk); bus_wr_i = 0; bus_rd_i = 0; tick_i = 0;
      end
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule